// File: doc/BRIEF.md
# Resolver Excitation Delay Unit

This unit sits between the excitation generator of a resolver-to-digital converter and the blocks that consume excitation timing. It has two delay paths. The first takes the excitation polarity bit, which arrives from a slower clock. It passes the bit through a two-flop synchronizer into the system clock domain. It then holds the bit back by a programmable number of system cycles before the bit feeds the demodulator and CIC filter. This delay makes up for the latency of the resolver, the analog parts and the ADC sampling window. The second path runs on the converter input clock. It shifts the ADC trigger by zero to three input clock cycles behind the excitation clock output, so that the ADC never samples while the excitation output is changing.

Software programs both delays through a single 16-bit register. The register accepts writes only while the converter is stopped. A separate enable input selects either the delayed paths or a direct bypass. The two delay settings and the enable are copied into a shadow set while the converter is stopped. The shadow set is frozen while the converter runs, so the delays cannot change during a conversion.

Top module: `resolver_exc_delay`

## Requirements
- R1: With the shadowed enable clear, `polFbOut` equals `polIn` as sampled two system clock edges earlier (the synchronizer latency only).
- R2: With the shadowed enable set and feedback field N (0 to 255), `polFbOut` equals the synchronized polarity delayed by N+1 further system cycles. N=0 adds 1 cycle and N=255 adds 256 cycles, so the end-to-end latency from `polIn` is N+3 system edges.
- R3: With the shadowed enable set and trigger field K, `adcTrig` equals `excClkIn` delayed by K input clock cycles. K=0 passes `excClkIn` straight through with no register.
- R4: A write attempted while `cvtRun` is high leaves both fields unchanged, and the unchanged values are seen in `rdData`.
- R5: With the shadowed enable clear, `adcTrig` follows `excClkIn` directly, whatever value the trigger field holds.
- R6: In `rdData`, bits 15:8 carry the feedback field and bits 1:0 carry the trigger field. Every other bit reads 0. Written data in the other bit positions is discarded.
- R7: After reset, both fields and the shadowed enable are 0, `rdData` is 0, `polFbOut` is 0 and `adcTrig` follows `excClkIn`.
- R8: The shadow set (enable, feedback field, trigger field) is loaded on each system clock edge where `cvtRun` is low, and it holds while `cvtRun` is high. A change of `dlyEnable` during a run has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock: register, synchronizer and feedback delay |
| inClk | input | 1 | Converter input clock: trigger delay |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| cvtRun | input | 1 | Converter enable; high locks the register and freezes the shadow set |
| dlyEnable | input | 1 | Selects the delay paths (1) or the bypass (0) |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data |
| polIn | input | 1 | Excitation polarity from the excitation clock domain |
| polFbOut | output | 1 | Synchronized, delayed polarity toward the CIC filter |
| excClkIn | input | 1 | Excitation clock output, input clock domain |
| adcTrig | output | 1 | Delayed ADC trigger |

## Verification
The bench builds the block with the default widths: an 8-bit feedback field, which makes the delay line 256 bits long, and a 2-bit trigger field, which gives four taps. At these sizes, one long run at field value 255 reaches the deepest tap, and small values (0, 1, 5) bring in the off-by-one edges. All four trigger taps are exercised against random input patterns. The two clocks run at periods that are not multiples of each other. The shadow crossing into the input clock domain is therefore tested at shifting phases, and runs with the enable toggled show that the frozen shadow set really holds.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  parameter int FB_DLY_W  = 8;   // feedback delay field width
  parameter int TRG_DLY_W = 2;   // trigger delay field width
  parameter int REG_W     = 16;  // register data width
  parameter int FB_LSB    = 8;   // feedback field position in the register
  parameter int TRG_LSB   = 0;   // trigger field position in the register

  // Strobes handed from the control block to the two delay paths.
  typedef struct packed {
    logic                 dlyOn;
    logic [FB_DLY_W-1:0]  fbTap;
    logic [TRG_DLY_W-1:0] trgTap;
  } rxdCfg_t;
endpackage

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
(
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             cvtRun,
  input  logic             dlyEnable,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output rxdCfg_t          cfg
);
  logic [FB_DLY_W-1:0]  regFbQ;
  logic [TRG_DLY_W-1:0] regTrgQ;
  rxdCfg_t              cfgQ;
  logic                 writeOk;
  logic                 unusedWr;

  assign writeOk  = wrEn && !cvtRun;
  assign unusedWr = ^wrData;

  // Software-visible fields: writable only while the converter is stopped.
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      regFbQ  <= '0;
      regTrgQ <= '0;
    end else if (writeOk) begin
      regFbQ  <= wrData[FB_LSB +: FB_DLY_W];
      regTrgQ <= wrData[TRG_LSB +: TRG_DLY_W];
    end
  end

  // Shadow set: follows the fields while stopped, frozen while running.
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (!cvtRun) begin
      cfgQ.dlyOn  <= dlyEnable;
      cfgQ.fbTap  <= regFbQ;
      cfgQ.trgTap <= regTrgQ;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[FB_LSB +: FB_DLY_W]   = regFbQ;
    rdData[TRG_LSB +: TRG_DLY_W] = regTrgQ;
  end

  assign cfg = cfgQ;

  AST_WRITE_LOCK: assert property (@(posedge sysClk) disable iff (!rstN)
    cvtRun |=> ($stable(regFbQ) && $stable(regTrgQ))); // R4

  AST_SHADOW_FROZEN: assert property (@(posedge sysClk) disable iff (!rstN)
    cvtRun |=> $stable(cfgQ)); // R8
endmodule

// File: rtl/rxd_fb_path.sv
module rxd_fb_path
  import rxd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                polIn,
  input  logic                dlyOn,
  input  logic [FB_DLY_W-1:0] fbTap,
  output logic                polFbOut
);
  localparam int LINE_LEN = 1 << FB_DLY_W;
  localparam int AGE_MAX  = SYNC_STAGES + 1;
  localparam int AGE_W    = $clog2(AGE_MAX + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   polSync;
  logic [LINE_LEN-1:0]    lineQ;
  logic                   tapBit;
  logic [AGE_W-1:0]       ageQ;

  // Synchronizer from the excitation clock domain.
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], polIn};
  end
  assign polSync = syncQ[SYNC_STAGES-1];

  // Delay line: tap i holds polSync from i+1 cycles ago.
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) lineQ <= '0;
    else       lineQ <= {lineQ[LINE_LEN-2:0], polSync};
  end
  assign tapBit   = lineQ[fbTap];
  assign polFbOut = dlyOn ? tapBit : polSync;

  // Edges since reset, saturating; qualifies the latency checks.
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                          ageQ <= '0;
    else if (ageQ != AGE_W'(AGE_MAX))   ageQ <= ageQ + 1'b1;
  end

  AST_FB_BYPASS_LATENCY: assert property (@(posedge sysClk) disable iff (!rstN)
    (ageQ >= AGE_W'(SYNC_STAGES) && !dlyOn) |-> (polFbOut == $past(polIn, SYNC_STAGES))); // R1

  AST_FB_MIN_DELAY: assert property (@(posedge sysClk) disable iff (!rstN)
    (ageQ >= AGE_W'(SYNC_STAGES) && dlyOn && fbTap == '0) |-> (polFbOut == $past(polSync))); // R2
endmodule

// File: rtl/rxd_trig_path.sv
module rxd_trig_path
  import rxd_pkg::*;
(
  input  logic                 inClk,
  input  logic                 rstN,
  input  logic                 excClkIn,
  input  logic                 dlyOnSys,
  input  logic [TRG_DLY_W-1:0] trgTapSys,
  output logic                 adcTrig
);
  localparam int TAP_CNT = 1 << TRG_DLY_W;

  logic [TRG_DLY_W:0]   cfgMetaQ;
  logic [TRG_DLY_W:0]   cfgQ;
  logic                 cfgOn;
  logic [TRG_DLY_W-1:0] cfgTap;
  logic [TAP_CNT-1:1]   stageQ;
  logic [TAP_CNT-1:0]   tapVec;
  logic                 primedQ;

  // Shadow settings are static while running; two flops bring them across.
  always_ff @(posedge inClk or negedge rstN) begin
    if (!rstN) begin
      cfgMetaQ <= '0;
      cfgQ     <= '0;
    end else begin
      cfgMetaQ <= {dlyOnSys, trgTapSys};
      cfgQ     <= cfgMetaQ;
    end
  end
  assign cfgOn  = cfgQ[TRG_DLY_W];
  assign cfgTap = cfgQ[TRG_DLY_W-1:0];

  // Tap 0 is the live input; tap k is the input k cycles ago.
  assign tapVec = {stageQ, excClkIn};
  always_ff @(posedge inClk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= tapVec[TAP_CNT-2:0];
  end

  assign adcTrig = cfgOn ? tapVec[cfgTap] : excClkIn;

  always_ff @(posedge inClk or negedge rstN) begin
    if (!rstN) primedQ <= 1'b0;
    else       primedQ <= 1'b1;
  end

  AST_TRIG_ONE_STAGE: assert property (@(posedge inClk) disable iff (!rstN)
    (primedQ && cfgOn && cfgTap == TRG_DLY_W'(1)) |-> (adcTrig == $past(excClkIn))); // R3
endmodule

// File: rtl/resolver_exc_delay.sv
module resolver_exc_delay
  import rxd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             sysClk,
  input  logic             inClk,
  input  logic             rstN,
  input  logic             cvtRun,
  input  logic             dlyEnable,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             polIn,
  output logic             polFbOut,
  input  logic             excClkIn,
  output logic             adcTrig
);
  rxdCfg_t cfg;

  rxd_ctrl u_ctrl (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .cvtRun    (cvtRun),
    .dlyEnable (dlyEnable),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rdData    (rdData),
    .cfg       (cfg)
  );

  rxd_fb_path #(.SYNC_STAGES(SYNC_STAGES)) u_fb (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .polIn    (polIn),
    .dlyOn    (cfg.dlyOn),
    .fbTap    (cfg.fbTap),
    .polFbOut (polFbOut)
  );

  rxd_trig_path u_trig (
    .inClk     (inClk),
    .rstN      (rstN),
    .excClkIn  (excClkIn),
    .dlyOnSys  (cfg.dlyOn),
    .trgTapSys (cfg.trgTap),
    .adcTrig   (adcTrig)
  );
endmodule

// File: tb/resolver_exc_delay_bench.sv
module resolver_exc_delay_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        sysClk = 1'b0;
  logic        inClk = 1'b0;
  logic        rstN = 1'b0;
  logic        cvtRun = 1'b0;
  logic        dlyEnable = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic        polIn = 1'b0;
  logic        polFbOut;
  logic        excClkIn = 1'b0;
  logic        adcTrig;

  always #2.5 sysClk = ~sysClk;   // 200 MHz
  always #3.5 inClk = ~inClk;

  resolver_exc_delay u_resolver_exc_delay (
    .sysClk(sysClk), .inClk(inClk), .rstN(rstN), .cvtRun(cvtRun),
    .dlyEnable(dlyEnable), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .polIn(polIn), .polFbOut(polFbOut), .excClkIn(excClkIn), .adcTrig(adcTrig)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  bit        fbHist [0:4095];
  bit        trHist [0:4095];
  int        tS = 0;
  int        tI = 0;
  logic [7:0] mRegFb = 0, mShFb = 0;
  logic [1:0] mRegTrg = 0, mShTrg = 0;
  bit        mShEn = 0;
  bit        chkTr = 0;
  bit        expFb, expTr;
  int        edgeNo, kTap;
  string     tag;

  function automatic bit fbGet(int i);
    return (i < 0 || i > 4095) ? 1'b0 : fbHist[i];
  endfunction
  function automatic bit trGet(int i);
    return (i < 0 || i > 4095) ? 1'b0 : trHist[i];
  endfunction

  // Random stimulus on the two data inputs.
  always @(negedge sysClk) polIn = 1'($urandom);

  always @(posedge sysClk) begin
    if (!rstN) begin
      tS = 0; mRegFb = 0; mRegTrg = 0; mShFb = 0; mShTrg = 0; mShEn = 0;
    end else begin
      edgeNo = tS;
      if (tS < 4096) fbHist[tS] = polIn;
      tS++;
      if (!cvtRun) begin
        mShEn = dlyEnable; mShFb = mRegFb; mShTrg = mRegTrg;
      end
      if (wrEn && !cvtRun) begin
        mRegFb = wrData[15:8]; mRegTrg = wrData[1:0];
      end
      #1;
      expFb = mShEn ? fbGet(edgeNo - 2 - int'(mShFb)) : fbGet(edgeNo - 1);
      if (cvtRun && (dlyEnable != mShEn)) tag = "R8";
      else if (mShEn) tag = "R2";
      else tag = "R1";
      check(polFbOut === expFb, tag, polFbOut, expFb);
      check(rdData === {mRegFb, 6'b0, mRegTrg}, cvtRun ? "R4" : "R6",
            rdData, {mRegFb, 6'b0, mRegTrg});
    end
  end

  always @(posedge inClk) begin
    if (!rstN) tI = 0;
    else begin
      if (tI < 4096) trHist[tI] = excClkIn;
      tI++;
    end
  end

  always @(negedge inClk) begin
    excClkIn = 1'($urandom);
    #1;
    if (rstN && chkTr) begin
      kTap = mShEn ? int'(mShTrg) : 0;
      expTr = (kTap == 0) ? excClkIn : trGet(tI - kTap);
      check(adcTrig === expTr, mShEn ? "R3" : "R5", adcTrig, expTr);
    end
  end

  task automatic sysCycles(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic writeReg(input logic [15:0] d);
    @(negedge sysClk);
    wrEn = 1'b1; wrData = d;
    @(negedge sysClk);
    wrEn = 1'b0; wrData = 16'($urandom);
  endtask

  task automatic reconfigure(input logic [15:0] d, input bit en);
    chkTr = 0;
    @(negedge sysClk) cvtRun = 1'b0;
    writeReg(d);
    dlyEnable = en;
    @(negedge sysClk) cvtRun = 1'b1;
    sysCycles(12);
    chkTr = 1;
  endtask

  initial begin
    sysCycles(5);
    check(rdData === 16'h0, "R7", rdData, 0);
    check(polFbOut === 1'b0, "R7", polFbOut, 0);
    #1;
    check(adcTrig === excClkIn, "R7", adcTrig, excClkIn);
    rstN = 1'b1;
    sysCycles(12);
    chkTr = 1;
    sysCycles(60);                       // R1, R5 with delays off

    writeReg(16'hA5FE);                  // R6: stray bits dropped
    check(rdData === 16'hA502, "R6", rdData, 16'hA502);

    reconfigure(16'h00FD, 1'b1);         // R2 field 0, R3 tap 1
    sysCycles(80);
    writeReg(16'h1203);                  // R4: locked while running
    check(rdData === 16'h0001, "R4", rdData, 16'h0001);
    dlyEnable = 1'b0;                    // R8: ignored mid-run
    sysCycles(40);

    reconfigure(16'h0502, 1'b1);         // R2 field 5, R3 tap 2
    sysCycles(80);
    reconfigure(16'hFF03, 1'b1);         // R2 field 255, R3 tap 3
    sysCycles(700);
    reconfigure(16'h0100, 1'b1);         // R2 field 1, R3 tap 0
    sysCycles(80);
    reconfigure(16'h0703, 1'b0);         // R5: bypass despite nonzero fields
    sysCycles(60);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule